// File: doc/BRIEF.md
# SPI Flash Serial Engine

This block is the serial core of an SPI master that talks to serial flash. Software sets it up through a small register port: a configuration word holds the mode, clock divisor, chip-select control and start control, a one-bit enable word turns the engine on, and a memory-select word steers the chip select to one of two attached memories. Transmit words arrive from an external transmit FIFO through a valid/ready handshake. Each word carries a byte-count tag. Every byte shifted out on MOSI is matched by one byte captured from MISO, which is pushed into an external receive FIFO.

The serial clock is the reference clock divided by a power of two between 2 and 256. All four combinations of clock polarity and phase are supported. Bits go out most significant first, and the bytes of a word go out lowest byte first. Chip select can follow a software bit or be driven automatically while a word is in flight. An optional manual-start mode holds the engine until software asks it to drain the transmit FIFO.

Top module: `spi_flash_eng`

## Requirements
- R1: After reset the configuration word reads 0x0000_0400 (chip-select bit 10 high, all else 0), the enable and memory-select words read 0, sclk is low, both chip-select outputs are high and txReady is low.
- R2: Configuration bits 5:3 hold a divisor code v. While a byte shifts, sclk toggles every 2^v reference cycles, so the divide ratio is 2 << v. The divider restarts at the start of every byte.
- R3: Configuration bit 1 (CPOL) sets the idle level of sclk. With bit 2 (CPHA) at 0, MOSI is valid before the first edge, MISO is sampled on leading edges and MOSI changes on trailing edges. With CPHA at 1, MOSI changes on leading edges and MISO is sampled on trailing edges. Each byte is sent most significant bit first.
- R4: txBytes values 1 to 3 send that many bytes of txData, and 0 sends all 4. The bytes are sent from the least significant byte upward.
- R5: Every byte sent produces exactly one single-cycle rxPush, with rxByte holding the 8 MISO bits captured during that byte, first bit in the MSB.
- R6: No word is accepted and sclk does not toggle unless bit 0 of the enable word (address 0x14) and configuration bit 0 (master) are both 1. Writing 0 to the enable bit drops txReady on the next cycle.
- R7: With configuration bit 14 set, the selected chip-select output follows configuration bit 10, active low. With bit 14 clear, the selected output is low from word acceptance until the last byte of the word has been pushed.
- R8: In the memory-select word (address 0xA0), bit 30 declares two memories and bit 28 picks the upper one. Chip select goes to csUpperN only when both bits are set; otherwise it goes to csLowerN. The unselected output stays high.
- R9: With configuration bit 15 set, no word is taken until a configuration write has bits 15 and 16 both set. The engine then takes words until the transmit FIFO is empty and stops. Bit 16 reads 1 while this drain is pending and 0 once it is done.
- R10: While rxFull is high, no new byte is started and sclk rests at its idle level.
- R11: Only one word is in flight at a time. txReady is high only while the engine is idle, and rxPush never occurs in the same cycle as txReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address (0x00 configuration, 0x14 enable, 0xA0 memory select) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| txValid | input | 1 | Transmit FIFO holds a word |
| txData | input | 32 | Transmit word, lowest byte sent first |
| txBytes | input | 2 | Byte-count tag (0 means four bytes) |
| txReady | output | 1 | Engine takes the word this cycle when txValid is high |
| rxFull | input | 1 | Receive FIFO cannot take a byte |
| rxPush | output | 1 | One received byte is presented this cycle |
| rxByte | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csLowerN | output | 1 | Chip select, lower memory, active low |
| csUpperN | output | 1 | Chip select, upper memory, active low |

## Verification
The properties assume that the transmit FIFO holds txValid and its data steady until the word is taken. They also assume that the configuration is not rewritten while a word is in flight and that rxFull only changes between bytes. The bench respects these limits. It waits for each phase to drain completely before it writes new modes, divisors or chip-select settings. It raises and drops rxFull only when a word has just been accepted or when the engine is idle. It feeds the transmit handshake from a queue whose head changes only after a completed handshake.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_BYTE_WAIT,
    S_SHIFT,
    S_PUSH
  } engState_t;

  // Strobes sent from the sequencer to the shift datapath.
  typedef struct packed {
    logic loadWord;
    logic loadByte;
    logic active;
    logic toggle;
    logic shiftOut;
    logic sampleIn;
  } dpStrobe_t;

  localparam int BITS_PER_BYTE = 8;

  // Register addresses and bit positions that software depends on.
  localparam logic [7:0] ADDR_CFG = 8'h00;
  localparam logic [7:0] ADDR_ENA = 8'h14;
  localparam logic [7:0] ADDR_MEM = 8'hA0;

  localparam int B_MASTER   = 0;
  localparam int B_CPOL     = 1;
  localparam int B_CPHA     = 2;
  localparam int B_BAUD     = 3;
  localparam int B_FWIDTH   = 6;
  localparam int B_CSLINE   = 10;
  localparam int B_CSMANUAL = 14;
  localparam int B_MSTARTEN = 15;
  localparam int B_MSTART   = 16;
  localparam int B_UPPER    = 28;
  localparam int B_TWOMEM   = 30;

endpackage

// File: rtl/spi_eng_datapath.sv
module spi_eng_datapath
  import spi_eng_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpStrobe_t                      strobe,
  input  logic [$clog2(WORD_W/8)-1:0]    byteSel,
  input  logic                           cpol,
  input  logic [DIV_W-1:0]               baudCode,
  input  logic [WORD_W-1:0]              wordIn,
  input  logic                           miso,
  output logic                           tick,
  output logic                           sclk,
  output logic                           mosi,
  output logic [BITS_PER_BYTE-1:0]       rxByte
);

  localparam int HALF_W = 1 << DIV_W;

  logic [WORD_W-1:0]        wordReg;
  logic [BITS_PER_BYTE-1:0] txShift;
  logic [BITS_PER_BYTE-1:0] rxShift;
  logic [HALF_W-1:0]        divCnt;
  logic [HALF_W-1:0]        halfM1;
  logic                     sclkReg;

  assign halfM1 = (HALF_W'(1) << baudCode) - HALF_W'(1);
  assign tick   = strobe.active && (divCnt == halfM1);

  // Half-period divider, restarted at each byte.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (strobe.loadByte || !strobe.active) begin
      divCnt <= '0;
    end else if (tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + HALF_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordReg <= '0;
    end else if (strobe.loadWord) begin
      wordReg <= wordIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      sclkReg <= 1'b0;
    end else if (strobe.loadByte) begin
      txShift <= wordReg[{byteSel, 3'b000} +: BITS_PER_BYTE];
      sclkReg <= cpol;
    end else begin
      if (strobe.toggle)   sclkReg <= ~sclkReg;
      if (strobe.shiftOut) txShift <= {txShift[BITS_PER_BYTE-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strobe.sampleIn) begin
      rxShift <= {rxShift[BITS_PER_BYTE-2:0], miso};
    end
  end

  assign sclk   = strobe.active ? sclkReg : cpol;
  assign mosi   = txShift[BITS_PER_BYTE-1];
  assign rxByte = rxShift;

endmodule

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 3,
  parameter int ADDR_W = 8,
  parameter int REG_W  = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWe,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [REG_W-1:0]               regWdata,
  output logic [REG_W-1:0]               regRdata,
  input  logic                           txValid,
  input  logic [$clog2(WORD_W/8)-1:0]    txBytes,
  output logic                           txReady,
  input  logic                           rxFull,
  input  logic                           tick,
  output logic                           rxPush,
  output dpStrobe_t                      strobe,
  output logic [$clog2(WORD_W/8)-1:0]    byteSel,
  output logic                           cpol,
  output logic [DIV_W-1:0]               baudCode,
  output logic                           csLowerN,
  output logic                           csUpperN
);

  localparam int BYTES  = WORD_W / 8;
  localparam int SEL_W  = $clog2(BYTES);
  localparam int EDGES  = 2 * BITS_PER_BYTE;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  // Software-visible settings
  logic             master, cpha, csLine, csManual, mStartEn, startPending;
  logic [1:0]       fifoWidth;
  logic             enReg, twoMem, upperSel;

  // Sequencer state
  engState_t        state;
  logic [SEL_W-1:0] byteIdx, lastIdx;
  logic [EDGE_W-1:0] edgeCnt;

  logic runOk, canTake, lead, busy, csDrive, pickUpper;

  assign runOk   = enReg && master;
  assign canTake = runOk && (!mStartEn || startPending);
  assign txReady = (state == S_IDLE) && canTake;
  assign rxPush  = (state == S_PUSH);
  assign busy    = (state != S_IDLE);
  assign byteSel = byteIdx;
  assign lead    = ~edgeCnt[0];

  wire unusedWdata = ^{regWdata[REG_W-1:B_TWOMEM+1], regWdata[B_TWOMEM-1],
                       regWdata[B_UPPER-1:B_MSTART+1], regWdata[B_CSMANUAL-1:B_CSLINE+1],
                       regWdata[B_CSLINE-1:B_FWIDTH+2]};

  // Register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      master       <= 1'b0;
      cpol         <= 1'b0;
      cpha         <= 1'b0;
      baudCode     <= '0;
      fifoWidth    <= '0;
      csLine       <= 1'b1;
      csManual     <= 1'b0;
      mStartEn     <= 1'b0;
      startPending <= 1'b0;
      enReg        <= 1'b0;
      twoMem       <= 1'b0;
      upperSel     <= 1'b0;
    end else begin
      if (regWe && regAddr == ADDR_CFG) begin
        master    <= regWdata[B_MASTER];
        cpol      <= regWdata[B_CPOL];
        cpha      <= regWdata[B_CPHA];
        baudCode  <= regWdata[B_BAUD +: DIV_W];
        fifoWidth <= regWdata[B_FWIDTH +: 2];
        csLine    <= regWdata[B_CSLINE];
        csManual  <= regWdata[B_CSMANUAL];
        mStartEn  <= regWdata[B_MSTARTEN];
        if (!regWdata[B_MSTARTEN])   startPending <= 1'b0;
        else if (regWdata[B_MSTART]) startPending <= 1'b1;
      end else if (startPending && state == S_IDLE && !txValid) begin
        startPending <= 1'b0;
      end
      if (regWe && regAddr == ADDR_ENA) enReg <= regWdata[0];
      if (regWe && regAddr == ADDR_MEM) begin
        twoMem   <= regWdata[B_TWOMEM];
        upperSel <= regWdata[B_UPPER];
      end
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CFG: begin
        regRdata[B_MASTER]           = master;
        regRdata[B_CPOL]             = cpol;
        regRdata[B_CPHA]             = cpha;
        regRdata[B_BAUD +: DIV_W]    = baudCode;
        regRdata[B_FWIDTH +: 2]      = fifoWidth;
        regRdata[B_CSLINE]           = csLine;
        regRdata[B_CSMANUAL]         = csManual;
        regRdata[B_MSTARTEN]         = mStartEn;
        regRdata[B_MSTART]           = startPending;
      end
      ADDR_ENA: regRdata[0] = enReg;
      ADDR_MEM: begin
        regRdata[B_TWOMEM] = twoMem;
        regRdata[B_UPPER]  = upperSel;
      end
      default: regRdata = '0;
    endcase
  end

  // Byte sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      byteIdx <= '0;
      lastIdx <= '0;
      edgeCnt <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (txValid && txReady) begin
            lastIdx <= (txBytes == '0) ? SEL_W'(BYTES - 1) : txBytes - SEL_W'(1);
            byteIdx <= '0;
            state   <= S_BYTE_WAIT;
          end
        end
        S_BYTE_WAIT: begin
          if (!runOk) begin
            state <= S_IDLE;
          end else if (!rxFull) begin
            edgeCnt <= '0;
            state   <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (!runOk) begin
            state <= S_IDLE;
          end else if (tick) begin
            edgeCnt <= edgeCnt + EDGE_W'(1);
            if (edgeCnt == LAST_EDGE) state <= S_PUSH;
          end
        end
        S_PUSH: begin
          if (byteIdx == lastIdx) begin
            state <= S_IDLE;
          end else begin
            byteIdx <= byteIdx + SEL_W'(1);
            state   <= S_BYTE_WAIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Strobes to the datapath
  always_comb begin
    strobe          = '0;
    strobe.loadWord = txValid && txReady;
    strobe.loadByte = (state == S_BYTE_WAIT) && runOk && !rxFull;
    strobe.active   = (state == S_SHIFT);
    strobe.toggle   = tick;
    strobe.sampleIn = tick && (lead ^ cpha);
    strobe.shiftOut = tick && (cpha ? (lead && edgeCnt != '0)
                                    : (!lead && edgeCnt != LAST_EDGE));
  end

  // Chip select and memory routing
  assign csDrive   = csManual ? csLine : ~busy;
  assign pickUpper = twoMem && upperSel;
  assign csLowerN  = pickUpper ? 1'b1 : csDrive;
  assign csUpperN  = pickUpper ? csDrive : 1'b1;

endmodule

// File: rtl/spi_flash_eng.sv
module spi_flash_eng
  import spi_eng_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 3,
  parameter int ADDR_W = 8,
  parameter int REG_W  = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWe,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [REG_W-1:0]            regWdata,
  output logic [REG_W-1:0]            regRdata,
  input  logic                        txValid,
  input  logic [WORD_W-1:0]           txData,
  input  logic [$clog2(WORD_W/8)-1:0] txBytes,
  output logic                        txReady,
  input  logic                        rxFull,
  output logic                        rxPush,
  output logic [7:0]                  rxByte,
  output logic                        sclk,
  output logic                        mosi,
  input  logic                        miso,
  output logic                        csLowerN,
  output logic                        csUpperN
);

  localparam int SEL_W = $clog2(WORD_W / 8);

  dpStrobe_t        strobe;
  logic [SEL_W-1:0] byteSel;
  logic             cpol, tick;
  logic [DIV_W-1:0] baudCode;

  spi_eng_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .txValid(txValid), .txBytes(txBytes), .txReady(txReady),
    .rxFull(rxFull), .tick(tick), .rxPush(rxPush), .strobe(strobe), .byteSel(byteSel),
    .cpol(cpol), .baudCode(baudCode), .csLowerN(csLowerN), .csUpperN(csUpperN)
  );

  spi_eng_datapath #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteSel(byteSel), .cpol(cpol),
    .baudCode(baudCode), .wordIn(txData), .miso(miso), .tick(tick), .sclk(sclk),
    .mosi(mosi), .rxByte(rxByte)
  );

endmodule

// File: rtl/spi_flash_eng_chk.sv
module spi_flash_eng_chk #(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [REG_W-1:0]  regWdata,
  input logic              txValid,
  input logic              txReady,
  input logic              rxPush,
  input logic              sclk
);

  // R11: a taken word makes the engine busy on the next cycle
  p_one_word_r11: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

  // R11: no byte is pushed while the engine is idle and ready
  p_no_push_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> !rxPush);

  // R5: each byte pushes exactly once
  p_push_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |=> !rxPush);

  // R3: the serial clock rests while idle and unconfigured
  p_idle_clock_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && !regWe) |=> $stable(sclk));

  // R6: clearing the enable bit stops acceptance at once
  p_enable_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(8'h14) && !regWdata[0]) |=> !txReady);

endmodule

bind spi_flash_eng spi_flash_eng_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .txValid(txValid), .txReady(txReady), .rxPush(rxPush), .sclk(sclk)
);

// File: tb/spi_flash_eng_tb.sv
module spi_flash_eng_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        txValid = 1'b0;
  logic [31:0] txData = '0;
  logic [1:0]  txBytes = '0;
  logic        txReady;
  logic        rxFull = 1'b0;
  logic        rxPush;
  logic [7:0]  rxByte;
  logic        sclk, mosi, csLowerN, csUpperN;
  logic        misoR = 1'b0;

  always #2 clk = ~clk;

  spi_flash_eng u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .txValid(txValid), .txData(txData), .txBytes(txBytes),
    .txReady(txReady), .rxFull(rxFull), .rxPush(rxPush), .rxByte(rxByte),
    .sclk(sclk), .mosi(mosi), .miso(misoR), .csLowerN(csLowerN), .csUpperN(csUpperN)
  );

  int total = 0;
  int bad = 0;

  logic [31:0] txDataQ[$];
  logic [1:0]  txTagQ[$];
  logic [7:0]  expQ[$];

  // Slave model state
  bit          slaveOn = 0;
  bit          csAutoChk = 0;
  logic        cpolB = 0, cphaB = 0;
  int          misoIdx = 0, capBits = 0, rxCnt = 0, mosiCnt = 0;
  int          edgeInByte = 0, sclkEdges = 0, divBad = 0;
  longint      lastT = 0, expDelta = 4;
  logic [7:0]  capSh = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] slvByte(input int j);
    return 8'h5A ^ 8'(j * 29 + 3);
  endfunction

  function automatic logic slvBit(input int k);
    logic [7:0] b;
    b = slvByte(k / 8);
    return b[7 - (k % 8)];
  endfunction

  // Transmit FIFO model
  always @(negedge clk) begin
    txValid = (txDataQ.size() > 0);
    if (txValid) begin
      txData  = txDataQ[0];
      txBytes = txTagQ[0];
    end
  end

  always @(posedge clk) begin
    if (rstN && txValid && txReady) begin
      void'(txDataQ.pop_front());
      void'(txTagQ.pop_front());
    end
  end

  // Driver: queue a word and its expected serial bytes (R4: low byte first)
  task automatic pushWord(input logic [31:0] d, input logic [1:0] tag);
    int n;
    n = (tag == 2'd0) ? 4 : int'(tag);
    txDataQ.push_back(d);
    txTagQ.push_back(tag);
    for (int i = 0; i < n; i++) expQ.push_back(d[8*i +: 8]);
  endtask

  // Slave: capture MOSI, drive MISO, time the edges
  always @(sclk) begin
    sclkEdges++;
    if (slaveOn) begin
      if (edgeInByte != 0 && ($time - lastT) != expDelta) divBad++;
      lastT = $time;
      edgeInByte = (edgeInByte + 1) % 16;
      if ((sclk != cpolB) ^ cphaB) begin
        capSh = {capSh[6:0], mosi};
        capBits++;
        if (capBits == 8) begin
          capBits = 0;
          mosiCnt++;
          if (expQ.size() == 0) begin
            chk(0, "R4 unexpected mosi byte", {24'd0, capSh}, 32'd0);
          end else begin
            logic [7:0] e;
            e = expQ.pop_front();
            chk(capSh == e, "R3 mosi byte", {24'd0, capSh}, {24'd0, e});
          end
        end
      end else if (!cphaB) begin
        misoIdx++;
        misoR = slvBit(misoIdx);
      end else begin
        misoR = slvBit(misoIdx);
        misoIdx++;
      end
    end
  end

  // Monitor for received bytes
  always @(negedge clk) begin
    if (rstN && rxPush) begin
      chk(rxByte == slvByte(rxCnt), "R5 rx byte", {24'd0, rxByte}, {24'd0, slvByte(rxCnt)});
      if (csAutoChk) chk(csLowerN == 1'b0, "R7 auto cs during word", {31'd0, csLowerN}, 32'd0);
      rxCnt++;
    end
  end

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  function automatic logic [31:0] cfgVal(input bit cp, input bit ch, input int baud, input bit mEn);
    return 32'h1 | (32'(cp) << 1) | (32'(ch) << 2) | (32'(baud) << 3) | (32'h1 << 10) | (32'(mEn) << 15);
  endfunction

  task automatic startPhase(input bit cp, input bit ch, input int baud, input bit mEn);
    slaveOn = 0;
    writeReg(8'h00, cfgVal(cp, ch, baud, mEn));
    @(negedge clk);
    cpolB = cp; cphaB = ch;
    misoIdx = 0; misoR = slvBit(0);
    capBits = 0; rxCnt = 0; mosiCnt = 0; edgeInByte = 0; divBad = 0;
    expDelta = longint'((1 << baud) * 4);
    slaveOn = 1;
  endtask

  task automatic waitDrain();
    int guard;
    guard = 0;
    while ((txDataQ.size() != 0 || expQ.size() != 0) && guard < 30000) begin
      @(negedge clk);
      guard++;
    end
    repeat (300) @(negedge clk);
  endtask

  task automatic endPhase(input string tag);
    chk(expQ.size() == 0, "R4 all expected bytes sent", expQ.size(), 0);
    chk(divBad == 0, "R2 sclk half period", divBad, 0);
    chk(rxCnt == mosiCnt, "R5 rx count equals tx count", rxCnt, mosiCnt);
    chk(sclk == cpolB, "R3 idle level", {31'd0, sclk}, {31'd0, cpolB});
    $display("phase %s done", tag);
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R11 act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    readReg(8'h00, rd); chk(rd == 32'h0000_0400, "R1 cfg reset", rd, 32'h400);
    readReg(8'h14, rd); chk(rd == 32'h0, "R1 enable reset", rd, 0);
    readReg(8'hA0, rd); chk(rd == 32'h0, "R1 memsel reset", rd, 0);
    chk(sclk == 1'b0 && csLowerN && csUpperN && !txReady, "R1 pins at reset",
        {28'd0, sclk, csLowerN, csUpperN, txReady}, 32'h6);

    // R6: master set but enable clear holds the word
    writeReg(8'h00, cfgVal(0, 0, 0, 0));
    pushWord(32'h0000_00A1, 2'd1);
    sclkEdges = 0;
    repeat (200) @(negedge clk);
    chk(txDataQ.size() == 1, "R6 word held while disabled", txDataQ.size(), 1);
    chk(sclkEdges == 0, "R6 no sclk while disabled", sclkEdges, 0);

    // Mode 0, divide by 2, all byte-count tags (R3, R4, R7 auto cs)
    csAutoChk = 1;
    startPhase(0, 0, 0, 0);
    writeReg(8'h14, 32'h1);
    pushWord(32'h4433_2211, 2'd0);
    pushWord(32'h00BB_CCDD, 2'd3);
    pushWord(32'h9988_7766, 2'd2);
    waitDrain();
    endPhase("mode0");
    chk(csLowerN == 1'b1, "R7 auto cs released", {31'd0, csLowerN}, 1);

    // Other modes and divisors (R2, R3)
    startPhase(0, 1, 1, 0);
    pushWord(32'hC3A5_0F81, 2'd0);
    waitDrain();
    endPhase("mode1");

    startPhase(1, 0, 2, 0);
    chk(sclk == 1'b1, "R3 cpol idle high", {31'd0, sclk}, 1);
    pushWord(32'h1234_5678, 2'd0);
    waitDrain();
    endPhase("mode2");

    startPhase(1, 1, 0, 0);
    pushWord(32'hFEDC_BA98, 2'd3);
    waitDrain();
    endPhase("mode3");

    startPhase(0, 0, 7, 0);
    pushWord(32'h0000_006D, 2'd1);
    waitDrain();
    endPhase("div256");

    // R10: receive FIFO full stalls the byte
    startPhase(0, 0, 1, 0);
    @(negedge clk); rxFull = 1'b1;
    pushWord(32'h0000_003C, 2'd1);
    sclkEdges = 0;
    repeat (100) @(negedge clk);
    chk(sclkEdges == 0, "R10 no sclk while rx full", sclkEdges, 0);
    chk(rxCnt == 0, "R10 no push while rx full", rxCnt, 0);
    rxFull = 1'b0;
    waitDrain();
    chk(rxCnt == 1, "R10 byte after release", rxCnt, 1);
    endPhase("rxfull");

    // R9: manual start
    startPhase(0, 0, 0, 1);
    pushWord(32'h0000_5511, 2'd2);
    pushWord(32'h0000_0022, 2'd1);
    sclkEdges = 0;
    repeat (100) @(negedge clk);
    chk(sclkEdges == 0, "R9 no start without trigger", sclkEdges, 0);
    chk(txDataQ.size() == 2, "R9 words held", txDataQ.size(), 2);
    readReg(8'h00, rd); chk(rd[16] == 1'b0, "R9 trigger bit idle", {31'd0, rd[16]}, 0);
    writeReg(8'h00, cfgVal(0, 0, 0, 1) | 32'h0001_0000);
    readReg(8'h00, rd); chk(rd[16] == 1'b1, "R9 trigger pending", {31'd0, rd[16]}, 1);
    waitDrain();
    readReg(8'h00, rd); chk(rd[16] == 1'b0, "R9 trigger cleared after drain", {31'd0, rd[16]}, 0);
    chk(rxCnt == 3, "R9 drained all bytes", rxCnt, 3);
    pushWord(32'h0000_0077, 2'd1);
    repeat (100) @(negedge clk);
    chk(txDataQ.size() == 1, "R9 stopped after drain", txDataQ.size(), 1);
    writeReg(8'h00, cfgVal(0, 0, 0, 1) | 32'h0001_0000);
    waitDrain();
    endPhase("manual start");

    // R7, R8: manual chip select and memory routing
    csAutoChk = 0;
    slaveOn = 0;
    writeReg(8'h00, 32'h0000_4001);
    @(negedge clk);
    chk(csLowerN == 1'b0 && csUpperN == 1'b1, "R7 manual cs low on lower",
        {30'd0, csLowerN, csUpperN}, 32'h1);
    writeReg(8'hA0, 32'h5000_0000);
    @(negedge clk);
    chk(csLowerN == 1'b1 && csUpperN == 1'b0, "R8 upper memory selected",
        {30'd0, csLowerN, csUpperN}, 32'h2);
    readReg(8'hA0, rd); chk(rd == 32'h5000_0000, "R8 memsel readback", rd, 32'h5000_0000);
    writeReg(8'hA0, 32'h1000_0000);
    @(negedge clk);
    chk(csLowerN == 1'b0 && csUpperN == 1'b1, "R8 upper ignored with one memory",
        {30'd0, csLowerN, csUpperN}, 32'h1);
    writeReg(8'h00, 32'h0000_4401);
    @(negedge clk);
    chk(csLowerN == 1'b1 && csUpperN == 1'b1, "R7 manual cs released",
        {30'd0, csLowerN, csUpperN}, 32'h3);

    // R6: clearing enable drops ready
    writeReg(8'h14, 32'h0);
    @(negedge clk);
    chk(txReady == 1'b0, "R6 ready low after disable", {31'd0, txReady}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule